// File: doc/BRIEF.md
# Analog-Shared Digital Port Controller

This block controls a set of digital pins that share their pads with analog converter inputs. It holds a direction register and an output latch for an 8-bit bidirectional port A. It also lets software read an 8-bit port B, which is input-only. Every pin level passes through a two-flop synchronizer before software can read it.

Two operating modes take some pins away from software control. In external multiplexer mode, two port A pins become outputs that carry a 2-bit multiplexed address. In trigger mode, two other port A pins become inputs for external trigger signals. Each trigger pin has its own enable. While a mode is active, the direction bits of its pins have no effect. Software can still write those bits, and the stored values take effect again once the mode is cleared.

Software uses a small register bus. Writes are single-cycle and reads are combinational. Address 0 is the data word: bits 15:8 are port A and bits 7:0 are port B. Address 1 is the direction word: bits 15:8 control port A and bits 7:0 are not implemented. Addresses 2 and 3 read as zero.

Top module: `gpio_ana_port`

## Requirements
- R1: Direction bit i (address 1, bit 8+i) set to 1 drives `pa_oe[i]` high, and `pa_out[i]` shows output latch bit i (address 0, bit 8+i). A direction bit cleared to 0 drives `pa_oe[i]` low. This holds for every pin not under an override.
- R2: While `xmux_en` is high, `pa_oe[1:0]` is 2'b11 and `pa_out[1:0]` equals `xaddr`, whatever the direction and latch bits hold.
- R3: While `xmux_en` is high, read bits 9:8 at address 0 return `xaddr`.
- R4: `trig1_en` high forces `pa_oe[3]` low, and `trig2_en` high forces `pa_oe[4]` low. The two enables act independently of each other and of the direction bits.
- R5: While a trigger enable is high, its data read bit (bit 11 for `trig1_en`, bit 12 for `trig2_en`) returns the synchronized pin level, whatever the direction bit holds.
- R6: At address 1, bits 7:0 read as zero and writes to them are ignored. Addresses 2 and 3 read as all zeros.
- R7: For a pin not under an override, data read bit 8+i returns the latch bit when the direction bit is 1, and the synchronized `pa_in[i]` when it is 0.
- R8: A pin level takes two rising edges to reach the read path. After a change, the read still shows the old level after the first rising edge and shows the new level after the second.
- R9: After reset, all direction bits and latch bits are 0. `pa_oe` and `pa_out` are then all zero.
- R10: Writes to the direction and latch registers are stored even while an override covers their pins. These stored values drive the pins as soon as the override is removed.
- R11: Data read bits 7:0 return synchronized `pb_in`, and writes to those bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 data, 1 direction |
| bus_wen | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| xmux_en | input | 1 | External multiplexer mode |
| xaddr | input | 2 | Multiplexed address driven onto port A bits 1:0 |
| trig1_en | input | 1 | Port A bit 3 acts as trigger input |
| trig2_en | input | 1 | Port A bit 4 acts as trigger input |
| pa_in | input | 8 | Port A pin levels |
| pa_oe | output | 8 | Port A output enables |
| pa_out | output | 8 | Port A output data |
| pb_in | input | 8 | Port B pin levels |

## Verification
The state that matters here is the stored direction and latch bits and the synchronizer stages. A corrupted direction or latch bit appears on `pa_oe` or `pa_out` in the cycle after the write. For an uncovered pin, it also appears in the next data read. A bit corrupted while an override is active stays hidden until the mode is cleared, so the bench writes under an override and then checks the pins right after release. A synchronizer with the wrong number of stages shifts the read by one edge, and the bench checks that edge count directly.

// File: rtl/gpio_ana_pkg.sv
package gpio_ana_pkg;
   localparam int unsigned ADDR_W   = 2;
   localparam logic [ADDR_W-1:0] ADR_DATA = 2'd0;
   localparam logic [ADDR_W-1:0] ADR_DIR  = 2'd1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else if (s == 0) stg[s] <= d;
         else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_reg_word.sv
module gpio_reg_word #(
   parameter int unsigned W    = 16,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & MASK;
   end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
   parameter int unsigned A_W       = 8,
   parameter int unsigned MUX_BIT0  = 0,
   parameter int unsigned TRIG1_BIT = 3,
   parameter int unsigned TRIG2_BIT = 4
) (
   input  logic [A_W-1:0] dir,
   input  logic [A_W-1:0] lat,
   input  logic [A_W-1:0] pin_s,
   input  logic           xmux_en,
   input  logic [1:0]     xaddr,
   input  logic           trig1_en,
   input  logic           trig2_en,
   output logic [A_W-1:0] oe,
   output logic [A_W-1:0] dout,
   output logic [A_W-1:0] rd
);
   for (genvar i = 0; i < A_W; i++) begin : g_pin
      logic plain_rd;
      assign plain_rd = dir[i] ? lat[i] : pin_s[i];
      if (i == MUX_BIT0 || i == MUX_BIT0 + 1) begin : g_mux
         localparam int unsigned K = i - MUX_BIT0;
         assign oe[i]   = xmux_en | dir[i];
         assign dout[i] = xmux_en ? xaddr[K] : lat[i];
         assign rd[i]   = xmux_en ? xaddr[K] : plain_rd;
      end else if (i == TRIG1_BIT || i == TRIG2_BIT) begin : g_trig
         logic grab;
         assign grab    = (i == TRIG1_BIT) ? trig1_en : trig2_en;
         assign oe[i]   = dir[i] & ~grab;
         assign dout[i] = lat[i];
         assign rd[i]   = grab ? pin_s[i] : plain_rd;
      end else begin : g_plain
         assign oe[i]   = dir[i];
         assign dout[i] = lat[i];
         assign rd[i]   = plain_rd;
      end
   end
endmodule

// File: rtl/gpio_ana_port.sv
module gpio_ana_port
   import gpio_ana_pkg::*;
#(
   parameter int unsigned A_W         = 8,
   parameter int unsigned B_W         = 8,
   parameter int unsigned MUX_BIT0    = 0,
   parameter int unsigned TRIG1_BIT   = 3,
   parameter int unsigned TRIG2_BIT   = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned BUS_W      = A_W + B_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              xmux_en,
   input  logic [1:0]        xaddr,
   input  logic              trig1_en,
   input  logic              trig2_en,
   input  logic [A_W-1:0]    pa_in,
   output logic [A_W-1:0]    pa_oe,
   output logic [A_W-1:0]    pa_out,
   input  logic [B_W-1:0]    pb_in
);
   localparam logic [BUS_W-1:0] A_MASK = {{A_W{1'b1}}, {B_W{1'b0}}};

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MUX_BIT0 + 1 >= A_W || TRIG1_BIT >= A_W || TRIG2_BIT >= A_W) begin : g_bad_pos
      $error("override pin positions must lie inside port A");
   end
   if (TRIG1_BIT == TRIG2_BIT || TRIG1_BIT == MUX_BIT0 || TRIG1_BIT == MUX_BIT0 + 1
       || TRIG2_BIT == MUX_BIT0 || TRIG2_BIT == MUX_BIT0 + 1) begin : g_bad_overlap
      $error("override pin positions must be distinct");
   end

   logic [BUS_W-1:0] dir_q, lat_q;
   logic [A_W-1:0]   pa_s, pa_rd;
   logic [B_W-1:0]   pb_s;
   logic [BUS_W-1:0] data_word;

   gpio_reg_word #(.W(BUS_W), .MASK(A_MASK)) u_dir (
      .clk(clk), .rst_n(rst_n),
      .we(bus_wen && bus_addr == ADR_DIR),
      .wdata(bus_wdata), .q(dir_q)
   );

   gpio_reg_word #(.W(BUS_W), .MASK(A_MASK)) u_lat (
      .clk(clk), .rst_n(rst_n),
      .we(bus_wen && bus_addr == ADR_DATA),
      .wdata(bus_wdata), .q(lat_q)
   );

   gpio_sync #(.W(A_W), .STAGES(SYNC_STAGES)) u_sync_a (
      .clk(clk), .rst_n(rst_n), .d(pa_in), .q(pa_s)
   );

   gpio_sync #(.W(B_W), .STAGES(SYNC_STAGES)) u_sync_b (
      .clk(clk), .rst_n(rst_n), .d(pb_in), .q(pb_s)
   );

   gpio_pin_mux #(
      .A_W(A_W), .MUX_BIT0(MUX_BIT0), .TRIG1_BIT(TRIG1_BIT), .TRIG2_BIT(TRIG2_BIT)
   ) u_mux (
      .dir(dir_q[BUS_W-1 -: A_W]), .lat(lat_q[BUS_W-1 -: A_W]), .pin_s(pa_s),
      .xmux_en(xmux_en), .xaddr(xaddr), .trig1_en(trig1_en), .trig2_en(trig2_en),
      .oe(pa_oe), .dout(pa_out), .rd(pa_rd)
   );

   // Low latch bits are held at zero by the mask, so merging them is neutral.
   assign data_word = {pa_rd, pb_s} | (lat_q & ~A_MASK);

   always_comb begin
      unique case (bus_addr)
         ADR_DATA: bus_rdata = data_word;
         ADR_DIR:  bus_rdata = dir_q;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_ana_chk.sv
module gpio_ana_chk #(
   parameter int unsigned A_W       = 8,
   parameter int unsigned B_W       = 8,
   parameter int unsigned MUX_BIT0  = 0,
   parameter int unsigned TRIG1_BIT = 3,
   parameter int unsigned TRIG2_BIT = 4,
   localparam int unsigned BUS_W    = A_W + B_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       bus_addr,
   input logic             bus_wen,
   input logic [BUS_W-1:0] bus_wdata,
   input logic [BUS_W-1:0] bus_rdata,
   input logic             xmux_en,
   input logic [1:0]       xaddr,
   input logic             trig1_en,
   input logic             trig2_en,
   input logic [A_W-1:0]   pa_oe,
   input logic [A_W-1:0]   pa_out
);
   AST_DIR_TOP_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wen && bus_addr == 2'd1 |=> pa_oe[A_W-1] == $past(bus_wdata[BUS_W-1])); // R1
   AST_MUX_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      xmux_en |-> pa_oe[MUX_BIT0 +: 2] == 2'b11 && pa_out[MUX_BIT0 +: 2] == xaddr); // R2
   AST_MUX_READ: assert property (@(posedge clk) disable iff (!rst_n)
      xmux_en && bus_addr == 2'd0 |-> bus_rdata[B_W + MUX_BIT0 +: 2] == xaddr); // R3
   AST_TRIG1_IN: assert property (@(posedge clk) disable iff (!rst_n)
      trig1_en |-> !pa_oe[TRIG1_BIT]); // R4
   AST_TRIG2_IN: assert property (@(posedge clk) disable iff (!rst_n)
      trig2_en |-> !pa_oe[TRIG2_BIT]); // R4
   AST_DIR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == 2'd1 |-> bus_rdata[B_W-1:0] == '0); // R6
   AST_HIGH_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr[1] |-> bus_rdata == '0); // R6
endmodule

bind gpio_ana_port gpio_ana_chk #(
   .A_W(A_W), .B_W(B_W), .MUX_BIT0(MUX_BIT0), .TRIG1_BIT(TRIG1_BIT), .TRIG2_BIT(TRIG2_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xmux_en(xmux_en), .xaddr(xaddr),
   .trig1_en(trig1_en), .trig2_en(trig2_en), .pa_oe(pa_oe), .pa_out(pa_out)
);

// File: tb/sim_gpio_ana_port.sv
module sim_gpio_ana_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_wen = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        xmux_en = 1'b0;
   logic [1:0]  xaddr = 2'd0;
   logic        trig1_en = 1'b0;
   logic        trig2_en = 1'b0;
   logic [7:0]  pa_in = '0;
   logic [7:0]  pa_oe, pa_out;
   logic [7:0]  pb_in = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] m_dir = '0;
   logic [7:0] m_lat = '0;

   always #2 clk = ~clk;

   gpio_ana_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xmux_en(xmux_en), .xaddr(xaddr),
      .trig1_en(trig1_en), .trig2_en(trig2_en), .pa_in(pa_in), .pa_oe(pa_oe),
      .pa_out(pa_out), .pb_in(pb_in)
   );

   function automatic logic [7:0] exp_oe(logic [7:0] d, logic mx, logic t1, logic t2);
      logic [7:0] o = d;
      if (mx) o[1:0] = 2'b11;
      if (t1) o[3] = 1'b0;
      if (t2) o[4] = 1'b0;
      return o;
   endfunction

   function automatic logic [7:0] exp_out(logic [7:0] l, logic mx, logic [1:0] xa);
      logic [7:0] o = l;
      if (mx) o[1:0] = xa;
      return o;
   endfunction

   function automatic logic [7:0] exp_rd(logic [7:0] d, logic [7:0] l, logic [7:0] p,
                                         logic mx, logic [1:0] xa, logic t1, logic t2);
      logic [7:0] o;
      for (int i = 0; i < 8; i++) o[i] = d[i] ? l[i] : p[i];
      if (mx) o[1:0] = xa;
      if (t1) o[3] = p[3];
      if (t2) o[4] = p[4];
      return o;
   endfunction

   task automatic check(string req, logic [15:0] got, logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wen = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wen = 1'b0;
      if (a == 2'd1) m_dir = d[15:8];
      if (a == 2'd0) m_lat = d[15:8];
   endtask

   task automatic rd(logic [1:0] a, output logic [15:0] v);
      bus_addr = a;
      #0.5;
      v = bus_rdata;
   endtask

   task automatic check_all(string tag);
      logic [15:0] v;
      check({tag, " oe"}, {8'h0, pa_oe}, {8'h0, exp_oe(m_dir, xmux_en, trig1_en, trig2_en)});
      check({tag, " out"}, {8'h0, pa_out}, {8'h0, exp_out(m_lat, xmux_en, xaddr)});
      rd(2'd0, v);
      check({tag, " data"}, v, {exp_rd(m_dir, m_lat, pa_in, xmux_en, xaddr, trig1_en, trig2_en), pb_in});
      rd(2'd1, v);
      check({tag, " dir"}, v, {m_dir, 8'h00});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 oe", {8'h0, pa_oe}, 16'h0);
      check("R9 out", {8'h0, pa_out}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(2'd1, v);
      check("R9 dir", v, 16'h0);

      // R6: low byte of direction ignores writes, upper addresses read zero
      wr(2'd1, 16'h00FF);
      rd(2'd1, v);
      check("R6 dir low", v, 16'h0000);
      rd(2'd2, v);
      check("R6 addr2", v, 16'h0);
      rd(2'd3, v);
      check("R6 addr3", v, 16'h0);

      // R1/R7: all outputs, then all inputs
      wr(2'd1, 16'hFF00);
      wr(2'd0, 16'hA5FF);
      check("R1 oe", {8'h0, pa_oe}, 16'h00FF);
      check("R1 out", {8'h0, pa_out}, 16'h00A5);
      rd(2'd0, v);
      check("R7 latch read / R11 low", v, 16'hA500);

      // R8: synchronizer latency with all pins as inputs
      wr(2'd1, 16'h0000);
      pa_in = 8'h3C; pb_in = 8'hC3;
      @(negedge clk);
      rd(2'd0, v);
      check("R8 one edge", v, 16'h0000);
      @(negedge clk);
      rd(2'd0, v);
      check("R8 two edges", v, 16'h3CC3);

      // R2/R3/R10: writes under mux mode, then release
      xmux_en = 1'b1; xaddr = 2'b10;
      wr(2'd1, 16'h0000);
      wr(2'd0, 16'h0100);
      check("R2 oe", {14'h0, pa_oe[1:0]}, 16'h0003);
      check("R2 out", {14'h0, pa_out[1:0]}, 16'h0002);
      rd(2'd0, v);
      check("R3 read", {14'h0, v[9:8]}, 16'h0002);
      wr(2'd1, 16'h0200);
      xmux_en = 1'b0;
      #0.5;
      check("R10 oe", {14'h0, pa_oe[1:0]}, 16'h0002);
      check("R10 out", {14'h0, pa_out[1:0]}, 16'h0001);

      // R4/R5: trigger pins set as outputs, one enable at a time
      wr(2'd1, 16'h1800);
      wr(2'd0, 16'h0000);
      pa_in = 8'h18;
      repeat (3) @(negedge clk);
      trig1_en = 1'b1;
      #0.5;
      check("R4 trig1 oe", {8'h0, pa_oe}, 16'h0010);
      rd(2'd0, v);
      check("R5 trig1 read", {8'h0, v[15:8] & 8'h18}, 16'h0008);
      trig1_en = 1'b0; trig2_en = 1'b1;
      #0.5;
      check("R4 trig2 oe", {8'h0, pa_oe}, 16'h0008);
      rd(2'd0, v);
      check("R5 trig2 read", {8'h0, v[15:8] & 8'h18}, 16'h0010);
      trig2_en = 1'b0;
      @(negedge clk);

      // Random mix covering R1 R2 R3 R4 R5 R7 R10 R11
      for (int it = 0; it < 60; it++) begin
         @(negedge clk);
         xmux_en  = 1'($urandom);
         xaddr    = 2'($urandom);
         trig1_en = 1'($urandom);
         trig2_en = 1'($urandom);
         wr(2'd1, 16'($urandom));
         wr(2'd0, 16'($urandom));
         pa_in = 8'($urandom);
         pb_in = 8'($urandom);
         repeat (3) @(negedge clk);
         check_all("R1 R2 R3 R4 R5 R7 R10 R11 rand");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule